// File: doc/BRIEF.md
# Virtual Carrier Sense Reservation Timer

This block holds the medium reservation that a wireless station learns from frames addressed to other stations. The receive path hands it a parsed 16-bit duration, a strobe marking that duration as valid, an end-of-frame pulse for the final received byte, and an abort pulse for a frame that must be thrown away. A captured duration is not used at once. It waits in a pending register until the frame completes. At that point it replaces the running reservation, but only if it is strictly longer than the time still left.

The reservation counts down once per microsecond and stops at zero. A free-running divider makes the microsecond tick from the system clock, with the division ratio set on an input. The block outputs a reservation-active flag. It also gates the physical channel-busy input with that flag, giving one medium-idle signal for the access logic. The physical channel only counts when no reservation is running.

Top module: `nav_timer`

## Requirements
- R1: A synchronous reset clears the reservation count and the pending duration. After reset, `nav_busy` is 0 and `medium_idle` equals the inverse of `cca_busy`.
- R2: A microsecond tick occurs on every (`cfg_div`+1)-th rising clock edge after reset is released, the first one on edge number `cfg_div`+1. Each tick lowers a non-zero count by one. A count of zero stays at zero.
- R3: A duration strobe with bit 15 equal to 0 is stored as pending. It does not change the count, and the count is held while the value waits. The count never grows except through a committed end of frame.
- R4: On an end-of-frame pulse with a valid pending duration and no abort, the count takes the pending value if that value is strictly greater than the current count. `nav_busy` reflects this one clock edge later. The pending value is consumed.
- R5: A committed pending value that is less than or equal to the current count leaves the count unchanged, apart from a tick in the same cycle.
- R6: An abort pulse discards the pending duration. A following end-of-frame pulse without a new strobe leaves the count unchanged.
- R7: A duration strobe whose bit 15 is 1 is ignored. It does not load the count and leaves any earlier pending value intact.
- R8: `medium_idle` is 1 only when the count is zero and `cca_busy` is 0. It follows `cca_busy` in the same cycle.
- R9: When abort and end of frame arrive in the same cycle, the abort wins and nothing is loaded.
- R10: When a load and a tick fall on the same edge, the load wins. The count becomes exactly the new value, not one less.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_div | input | 8 | Clock cycles per microsecond minus one |
| dur_valid | input | 1 | Parsed duration strobe |
| dur_value | input | 16 | Parsed duration in microseconds (bit 15 set: not a reservation) |
| frame_end | input | 1 | Last byte of the received frame delivered |
| frame_abort | input | 1 | Received frame dropped (for example a bad checksum) |
| cca_busy | input | 1 | Physical channel busy from the radio |
| nav_busy | output | 1 | Reservation count is non-zero |
| medium_idle | output | 1 | Neither reservation nor physical channel is busy |

## Verification
The count is one register, so a load or a decrement shows on `nav_busy` one clock edge after the input or tick that caused it. `medium_idle` responds to `cca_busy` in the same cycle. The bench drives each cycle's inputs just after the falling edge and advances its own timing model by one edge. It queues the expected flags, and the monitor compares them 5 ns after the next rising edge. Every cycle is compared, so the exact cycle in which a reservation expires is checked as well as its value. Same-edge collisions of tick with load and of abort with end are steered deliberately, using the bench's own tick phase.

// File: rtl/nav_pkg.sv
package nav_pkg;
  localparam int NAV_W = 16;
  typedef logic [NAV_W-1:0] nav_t;

  // bit 15 marks a non-time value
  function automatic logic is_reservation(input nav_t d);
    return ~d[NAV_W-1];
  endfunction

  // strictly longer reservation replaces the running one
  function automatic logic longer_than(input nav_t cand, input nav_t cur);
    return cand > cur;
  endfunction

  function automatic nav_t dec_sat(input nav_t v);
    return (v == '0) ? v : nav_t'(v - 1'b1);
  endfunction
endpackage

// File: rtl/nav_tick_gen.sv
module nav_tick_gen #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [DIV_W-1:0] cfg_div,
  output logic             tick
);
  logic [DIV_W-1:0] phase_q;
  logic             wrap;

  assign wrap = (phase_q == cfg_div);
  assign tick = wrap;

  always_ff @(posedge clk) begin
    if (rst)       phase_q <= '0;
    else if (wrap) phase_q <= '0;
    else           phase_q <= phase_q + 1'b1;
  end

  assert_tick_gap_R2: assert property (@(posedge clk) disable iff (rst)
    (tick && cfg_div != '0 && $stable(cfg_div)) |=> !tick);
endmodule

// File: rtl/nav_pending.sv
module nav_pending
  import nav_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic dur_valid,
  input  nav_t dur_value,
  input  logic frame_end,
  input  logic frame_abort,
  output logic pend_valid,
  output nav_t pend_val,
  output logic commit
);
  logic capture;

  assign capture = dur_valid && is_reservation(dur_value);
  assign commit  = frame_end && !frame_abort && pend_valid;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_valid <= 1'b0;
      pend_val   <= '0;
    end else if (frame_abort) begin
      pend_valid <= 1'b0;
    end else if (capture) begin
      pend_valid <= 1'b1;
      pend_val   <= dur_value;
    end else if (frame_end) begin
      pend_valid <= 1'b0;
    end
  end

  assert_abort_drop_R6: assert property (@(posedge clk) disable iff (rst)
    frame_abort |=> !pend_valid);

  assert_flag_ignored_R7: assert property (@(posedge clk) disable iff (rst)
    (dur_valid && dur_value[NAV_W-1] && !frame_abort && !frame_end)
      |=> ($stable(pend_valid) && $stable(pend_val)));

  assert_abort_wins_R9: assert property (@(posedge clk) disable iff (rst)
    (frame_abort && frame_end) |-> !commit);
endmodule

// File: rtl/nav_counter.sv
module nav_counter
  import nav_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic commit,
  input  nav_t pend_val,
  output nav_t nav_q
);
  logic take;

  assign take = commit && longer_than(pend_val, nav_q);

  always_ff @(posedge clk) begin
    if (rst)       nav_q <= '0;
    else if (take) nav_q <= pend_val;
    else if (tick) nav_q <= dec_sat(nav_q);
  end

  assert_load_R4: assert property (@(posedge clk) disable iff (rst)
    (commit && pend_val > nav_q) |=> (nav_q == $past(pend_val)));

  assert_keep_R5: assert property (@(posedge clk) disable iff (rst)
    (commit && pend_val <= nav_q && !tick) |=> $stable(nav_q));

  assert_floor_R2: assert property (@(posedge clk) disable iff (rst)
    (nav_q == '0 && !commit) |=> (nav_q == '0));

  assert_idle_hold_R2: assert property (@(posedge clk) disable iff (rst)
    (!commit && !tick) |=> $stable(nav_q));
endmodule

// File: rtl/nav_timer.sv
module nav_timer
  import nav_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [DIV_W-1:0] cfg_div,
  input  logic             dur_valid,
  input  logic [15:0]      dur_value,
  input  logic             frame_end,
  input  logic             frame_abort,
  input  logic             cca_busy,
  output logic             nav_busy,
  output logic             medium_idle
);
  logic tick;
  logic pend_valid;
  logic commit;
  nav_t pend_val;
  nav_t nav_q;

  nav_tick_gen #(.DIV_W(DIV_W)) u_tick (
    .clk(clk), .rst(rst), .cfg_div(cfg_div), .tick(tick)
  );

  nav_pending u_pend (
    .clk(clk), .rst(rst), .dur_valid(dur_valid), .dur_value(dur_value),
    .frame_end(frame_end), .frame_abort(frame_abort),
    .pend_valid(pend_valid), .pend_val(pend_val), .commit(commit)
  );

  nav_counter u_cnt (
    .clk(clk), .rst(rst), .tick(tick), .commit(commit),
    .pend_val(pend_val), .nav_q(nav_q)
  );

  assign nav_busy    = (nav_q != '0);
  assign medium_idle = !nav_busy && !cca_busy;

  assert_no_growth_R3: assert property (@(posedge clk) disable iff (rst)
    !commit |=> (nav_q <= $past(nav_q)));

  assert_reset_R1: assert property (@(posedge clk)
    rst |=> (nav_q == '0 && !pend_valid));
endmodule

// File: tb/nav_timer_tb.sv
`timescale 1ns/1ps
module nav_timer_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  cfg_div = 8'd3;
  logic        dur_valid = 1'b0;
  logic [15:0] dur_value = '0;
  logic        frame_end = 1'b0;
  logic        frame_abort = 1'b0;
  logic        cca_busy = 1'b0;
  logic        nav_busy, medium_idle;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  string q_tag[$];
  bit    q_busy[$];
  bit    q_idle[$];

  // reference model state
  int m_ph = 0;
  int m_nav = 0;
  bit m_pv = 0;
  int m_pval = 0;

  always #10 clk = ~clk;

  nav_timer u_dut (
    .clk(clk), .rst(rst), .cfg_div(cfg_div), .dur_valid(dur_valid),
    .dur_value(dur_value), .frame_end(frame_end), .frame_abort(frame_abort),
    .cca_busy(cca_busy), .nav_busy(nav_busy), .medium_idle(medium_idle)
  );

  // monitor: compares mid-high-phase after each rising edge
  always @(posedge clk) begin
    #5;
    if (q_tag.size() > 0) begin
      string t;
      bit eb, ei;
      t  = q_tag.pop_front();
      eb = q_busy.pop_front();
      ei = q_idle.pop_front();
      n_chk++;
      if (nav_busy !== eb || medium_idle !== ei) begin
        n_bad++;
        $display("FAIL %s: busy=%b idle=%b expected busy=%b idle=%b",
                 t, nav_busy, medium_idle, eb, ei);
      end
    end
  end

  // driver: one clock per call; model advances one edge and queues result
  task automatic cyc(input bit dv, input logic [15:0] d, input bit fe,
                     input bit fa, input bit cb, input string tag);
    bit tk, cm;
    dur_valid = dv; dur_value = d; frame_end = fe;
    frame_abort = fa; cca_busy = cb;
    if (rst) begin
      m_ph = 0; m_nav = 0; m_pv = 0; m_pval = 0;
    end else begin
      tk = (m_ph == int'(cfg_div));
      m_ph = tk ? 0 : m_ph + 1;
      cm = fe && !fa && m_pv;
      if (cm && m_pval > m_nav) m_nav = m_pval;
      else if (tk && m_nav > 0) m_nav = m_nav - 1;
      if (fa) m_pv = 0;
      else if (dv && !d[15]) begin m_pv = 1; m_pval = int'(d); end
      else if (fe) m_pv = 0;
    end
    q_tag.push_back(tag);
    q_busy.push_back(m_nav != 0);
    q_idle.push_back((m_nav == 0) && !cb);
    @(negedge clk);
  endtask

  task automatic idle(input int n, input bit cb, input string tag);
    for (int i = 0; i < n; i++) cyc(0, 16'h0, 0, 0, cb, tag);
  endtask

  task automatic drain(input string tag);
    int guard = 0;
    while (m_nav != 0 && guard < 100000) begin
      cyc(0, 16'h0, 0, 0, 0, tag);
      guard++;
    end
    idle(3, 0, tag);
  endtask

  initial begin
    #(20 * 100000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    // R1: reset state with both channel levels
    rst = 1'b1;
    idle(2, 0, "R1 reset cca0");
    idle(2, 1, "R1 reset cca1");
    rst = 1'b0;
    idle(2, 1, "R1 after reset cca1");
    idle(2, 0, "R1 after reset cca0");

    // R3: captured value waits, no count yet
    cyc(1, 16'd5, 0, 0, 0, "R3 capture");
    idle(12, 0, "R3 pending held");

    // R4 + R2: commit then countdown to zero, R8 with channel high
    cyc(0, 16'h0, 1, 0, 0, "R4 commit 5");
    idle(6, 1, "R8 busy cca1");
    drain("R2 countdown 5");

    // R5: smaller and equal values ignored
    cyc(1, 16'd20, 0, 0, 0, "R4 capture 20");
    cyc(0, 16'h0, 1, 0, 0, "R4 commit 20");
    idle(4, 0, "R2 run");
    cyc(1, 16'd3, 0, 0, 0, "R5 capture 3");
    cyc(0, 16'h0, 1, 0, 0, "R5 commit smaller");
    idle(2, 0, "R5 after smaller");
    cyc(1, 16'(m_nav), 0, 0, 0, "R5 capture equal");
    cyc(0, 16'h0, 1, 0, 0, "R5 commit equal");
    drain("R5 drain");

    // R6: abort discards
    cyc(1, 16'd8, 0, 0, 0, "R6 capture");
    cyc(0, 16'h0, 0, 1, 0, "R6 abort");
    cyc(0, 16'h0, 1, 0, 0, "R6 end after abort");
    idle(4, 0, "R6 nothing loaded");

    // R7: flagged value ignored, earlier pending kept
    cyc(1, 16'h8005, 0, 0, 0, "R7 flagged only");
    cyc(0, 16'h0, 1, 0, 0, "R7 end flagged");
    idle(3, 0, "R7 nothing loaded");
    cyc(1, 16'd6, 0, 0, 0, "R7 capture 6");
    cyc(1, 16'h8010, 0, 0, 0, "R7 flagged after 6");
    cyc(0, 16'h0, 1, 0, 0, "R7 commit keeps 6");
    drain("R7 drain 6");

    // R9: abort and end together
    cyc(1, 16'd9, 0, 0, 0, "R9 capture");
    cyc(0, 16'h0, 1, 1, 0, "R9 abort with end");
    cyc(0, 16'h0, 1, 0, 0, "R9 later end");
    idle(4, 0, "R9 nothing loaded");

    // R10: commit exactly on a tick edge
    cyc(1, 16'd2, 0, 0, 0, "R10 capture 2");
    while (m_ph != int'(cfg_div)) cyc(0, 16'h0, 0, 0, 0, "R10 align");
    cyc(0, 16'h0, 1, 0, 0, "R10 commit on tick");
    drain("R10 exact length");

    // R8: channel toggling while no reservation
    for (int i = 0; i < 6; i++) cyc(0, 16'h0, 0, 0, bit'(i[0]), "R8 cca toggle");

    // R2: divide by one, tick every edge
    rst = 1'b1; cfg_div = 8'd0;
    idle(2, 0, "R1 reset again");
    rst = 1'b0;
    cyc(1, 16'd3, 0, 0, 0, "R2 div0 capture");
    cyc(0, 16'h0, 1, 0, 0, "R2 div0 commit");
    drain("R2 div0 countdown");

    // R2: divide by eight
    cfg_div = 8'd7;
    rst = 1'b1; idle(1, 0, "R1 reset div7");
    rst = 1'b0;
    cyc(1, 16'd4, 0, 0, 0, "R2 div7 capture");
    cyc(0, 16'h0, 1, 0, 0, "R2 div7 commit");
    drain("R2 div7 countdown");

    @(negedge clk);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule